// File: doc/BRIEF.md
# Configurable External Interrupt Unit

This block takes a bank of external interrupt request lines and forwards each one to the interrupt line of the same index on a system interrupt controller. For each line, software chooses level or edge sensing and the active polarity. The block holds every detected condition in a per-line request bit until software clears it. Whatever the input type, each output is an active-high level, so a downstream controller only ever sees level-sensitive requests. An edge event therefore becomes a sticky level that stays high until software acknowledges it.

Every input first passes through a two-stage synchroniser. Edges are found by comparing the synchronised value with its value on the previous cycle. A per-line mask blocks only the output. Requests are still latched while a line is masked, so when software unmasks the line, any pending request appears at once. Software reaches the block through eight 32-bit word registers. Each write takes effect on a single-cycle write strobe. Reads are combinational from the address.

Top module: `ext_irq_unit`

## Requirements
- R1: Registers are decoded from byte address bits [4:2]. The offsets are 0x00 mask, 0x04 source select, 0x08 masked status, 0x0C raw status, 0x10 request clear, 0x14 polarity, 0x18 edge select and 0x1C auxiliary. Bit n of each register belongs to line n.
- R2: After a synchronous active-low reset, the register values are as follows:
  - mask reads all ones;
  - polarity reads all ones;
  - edge select, source select, auxiliary and raw status read zero;
  - irq_out is all zero.
- R3: A change on irq_in that is driven between clock edges reaches the raw status on the third following rising edge, not earlier.
- R4: When a line's edge bit is 0, the line uses level sensing. Polarity 1 means active high and polarity 0 means active low. The raw request is set on every cycle the active condition is seen. It stays set after the condition goes away, until software clears it. A clear issued while the condition is still active leaves the request set.
- R5: When a line's edge bit is 1, the line uses edge sensing. Polarity 1 detects a rising edge and polarity 0 detects a falling edge. One detected edge sets the raw request, which then stays set until it is cleared.
- R6: Writing a 1 to a bit of the request clear register clears that line's request. Writing a 0 leaves the request unchanged. The clear register reads as zero.
- R7: If a new edge and a clear for the same line arrive in the same cycle, the request stays set.
- R8: A mask bit of 1 holds that irq_out line low. Requests keep latching while the line is masked. Clearing the mask bit raises irq_out on the next cycle if a request is pending.
- R9: The masked status register and irq_out both equal the raw status ANDed with the inverted mask.
- R10: Writes to the two status registers are ignored. Source select and auxiliary are read/write storage that has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | External interrupt inputs, asynchronous |
| irq_out | output | NUM_LINES | Active-high level requests to the interrupt controller |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |

## Verification
The bench builds the block with its defaults: 32 lines, a 32-bit data word and a 5-bit byte address. With these values every bit position of every register maps to a real line, so random writes and reads cover the full word. The default synchroniser depth of two is what gives the three-edge latency that the bench counts against. Random toggling of the inputs, mixed with random rewrites of mode, polarity, mask and clear, exercises many lines at once while they run in different sensing modes. Directed sequences place a clear on the exact edge where a new edge lands, and issue a clear while a level input is still active.

// File: rtl/xint_pkg.sv
// Shared register index encoding for the external interrupt unit.
// Assumes word-aligned access; index is byte address bits [4:2].
package xint_pkg;
    typedef enum logic [2:0] {
        IDX_MASK = 3'd0,
        IDX_SRC  = 3'd1,
        IDX_STAT = 3'd2,
        IDX_RAW  = 3'd3,
        IDX_CLR  = 3'd4,
        IDX_POL  = 3'd5,
        IDX_EDGE = 3'd6,
        IDX_AUX  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/xint_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherence is promised.
module xint_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= async_i;
                end
            end else begin : g_next
                // pass the value one stage further down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/xint_sense.sv
// Per-line sensing and request latching. Uses level or edge sensing with a
// selectable polarity, holds requests until cleared, and gates each output
// with its mask. Assumes sync_i is already in the clk domain.
module xint_sense #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] edge_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] raw_q;
    logic [N-1:0] set_w;

    // remember last cycle's synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            logic active_w;
            logic edge_w;
            // condition seen this cycle, after polarity is applied
            always_comb begin
                active_w = pol_i[i] ? sync_i[i] : ~sync_i[i];
                edge_w   = pol_i[i] ? (sync_i[i] & ~prev_q[i])
                                    : (~sync_i[i] & prev_q[i]);
                set_w[i] = edge_i[i] ? edge_w : active_w;
            end
            // sticky request: a new set wins over a clear
            always_ff @(posedge clk) begin
                if (!rst_n) raw_q[i] <= 1'b0;
                else        raw_q[i] <= set_w[i] | (raw_q[i] & ~clr_i[i]);
            end
        end
    endgenerate

    assign raw_o = raw_q;
    assign irq_o = raw_q & ~mask_i;

    // R5: a request not cleared stays set
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(raw_q & ~clr_i)) == $past(raw_q & ~clr_i)));
    // R6: a clear without a concurrent set drops the request
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(clr_i & ~set_w)) == '0));
    // R7: a detected condition always leaves the request set
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(set_w)) == $past(set_w)));
endmodule

// File: rtl/xint_regs.sv
// Word register file: configuration storage, clear strobe and status readback.
// Assumes one write per strobe cycle and N <= DW.
module xint_regs
    import xint_pkg::*;
#(
    parameter int N  = 32,
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  raw_i,
    input  logic [N-1:0]  masked_i,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  edge_o,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata_o
);
    reg_idx_e     idx_w;
    logic [N-1:0] mask_q, pol_q, edge_q, src_q, aux_q;

    assign idx_w = reg_idx_e'(addr_i[4:2]);

    function automatic logic [DW-1:0] zext(input logic [N-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[N-1:0] = v;
        return r;
    endfunction

    // configuration storage updated by writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '1;
            edge_q <= '0;
            src_q  <= '0;
            aux_q  <= '0;
        end else if (wr_i) begin
            case (idx_w)
                IDX_MASK: mask_q <= wdata_i[N-1:0];
                IDX_SRC:  src_q  <= wdata_i[N-1:0];
                IDX_POL:  pol_q  <= wdata_i[N-1:0];
                IDX_EDGE: edge_q <= wdata_i[N-1:0];
                IDX_AUX:  aux_q  <= wdata_i[N-1:0];
                default: ;
            endcase
        end
    end

    // one-cycle clear strobe from a write to the clear register
    always_comb begin
        clr_o = '0;
        if (wr_i && idx_w == IDX_CLR) clr_o = wdata_i[N-1:0];
    end

    // read multiplexer
    always_comb begin
        case (idx_w)
            IDX_MASK: rdata_o = zext(mask_q);
            IDX_SRC:  rdata_o = zext(src_q);
            IDX_STAT: rdata_o = zext(masked_i);
            IDX_RAW:  rdata_o = zext(raw_i);
            IDX_POL:  rdata_o = zext(pol_q);
            IDX_EDGE: rdata_o = zext(edge_q);
            IDX_AUX:  rdata_o = zext(aux_q);
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;
    assign pol_o  = pol_q;
    assign edge_o = edge_q;

    // R10: status writes leave configuration untouched
    assert_status_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (idx_w == IDX_STAT || idx_w == IDX_RAW)) |=>
        ($stable(mask_q) && $stable(pol_q) && $stable(edge_q)
         && $stable(src_q) && $stable(aux_q)));
endmodule

// File: rtl/ext_irq_unit.sv
// External interrupt unit top: synchroniser, per-line sensing and registers.
// Assumes irq_in is asynchronous and bus access is synchronous to clk.
module ext_irq_unit
    import xint_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata
);
    logic [NUM_LINES-1:0] sync_w, raw_w, mask_w, pol_w, edge_w, clr_w;

    xint_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_in), .sync_o(sync_w)
    );

    xint_sense #(.N(NUM_LINES)) u_sense (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .pol_i(pol_w),
        .edge_i(edge_w), .clr_i(clr_w), .mask_i(mask_w),
        .raw_o(raw_w), .irq_o(irq_out)
    );

    xint_regs #(.N(NUM_LINES), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .raw_i(raw_w), .masked_i(irq_out),
        .mask_o(mask_w), .pol_o(pol_w), .edge_o(edge_w), .clr_o(clr_w),
        .rdata_o(bus_rdata)
    );

    // R8: a masked line never drives its output
    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask_w) == '0);
    // R9: masked status readback matches the output vector
    assert_stat_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:2] == 3'd2) |-> (bus_rdata[NUM_LINES-1:0] == irq_out));
endmodule

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;
    localparam int N = 32;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] irq_out;
    logic bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // reference model built from the requirements
    logic [N-1:0] m_s1, m_s2, m_prev, m_raw, m_mask, m_pol, m_edge, m_src, m_aux;
    always @(posedge clk) begin
        logic [N-1:0] act, evt, setv, clr;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0;
            m_mask <= '1; m_pol <= '1; m_edge <= '0; m_src <= '0; m_aux <= '0;
        end else begin
            act  = ~(m_s2 ^ m_pol);
            evt  = (m_s2 & ~m_prev & m_pol) | (~m_s2 & m_prev & ~m_pol);
            setv = (m_edge & evt) | (~m_edge & act);
            clr  = (bus_wr && bus_addr[4:2] == 3'd4) ? bus_wdata : '0;
            m_raw  <= setv | (m_raw & ~clr);
            m_s1   <= irq_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            if (bus_wr) begin
                case (bus_addr[4:2])
                    3'd0: m_mask <= bus_wdata;
                    3'd1: m_src  <= bus_wdata;
                    3'd5: m_pol  <= bus_wdata;
                    3'd6: m_edge <= bus_wdata;
                    3'd7: m_aux  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_reg(input logic [2:0] idx);
        case (idx)
            3'd0: return m_mask;
            3'd1: return m_src;
            3'd2: return m_raw & ~m_mask;
            3'd3: return m_raw;
            3'd5: return m_pol;
            3'd6: return m_edge;
            3'd7: return m_aux;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read a register at the current negedge and compare with the model
    task automatic rd_chk(input string req, input logic [2:0] idx);
        bus_addr = {idx, 2'b00};
        #1;
        chk(req, bus_rdata, exp_reg(idx));
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state, with explicit constants
        bus_addr = 5'h00; #1; chk("R2 mask", bus_rdata, 32'hFFFF_FFFF);
        bus_addr = 5'h14; #1; chk("R2 pol", bus_rdata, 32'hFFFF_FFFF);
        bus_addr = 5'h18; #1; chk("R2 edge", bus_rdata, 32'h0);
        bus_addr = 5'h0C; #1; chk("R2 raw", bus_rdata, 32'h0);
        chk("R2 irq_out", irq_out, 32'h0);
        // R1 map and R10 storage registers
        wr(3'd7, 32'hA5A5_3C3C);
        wr(3'd1, 32'h1234_ABCD);
        bus_addr = 5'h1C; #1; chk("R1 R10 aux", bus_rdata, 32'hA5A5_3C3C);
        bus_addr = 5'h04; #1; chk("R1 R10 src", bus_rdata, 32'h1234_ABCD);
        // R10 status writes ignored
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd_chk("R10 raw unchanged", 3'd3);
        bus_addr = 5'h00; #1; chk("R10 mask unchanged", bus_rdata, 32'hFFFF_FFFF);
        // R6 clear reads zero
        bus_addr = 5'h10; #1; chk("R6 clear reads 0", bus_rdata, 32'h0);

        // R3 latency on line 0 in level mode
        wr(3'd0, 32'hFFFF_FFFE);
        irq_in[0] = 1'b1;
        wait_n(2);
        bus_addr = 5'h0C; #1; chk("R3 not yet", bus_rdata & 32'h1, 32'h0);
        wait_n(1);
        bus_addr = 5'h0C; #1; chk("R3 third edge", bus_rdata & 32'h1, 32'h1);
        chk("R9 irq_out line0", irq_out & 32'h1, 32'h1);
        // R4 clear while active keeps it set
        wr(3'd4, 32'h1);
        bus_addr = 5'h0C; #1; chk("R4 clear while active", bus_rdata & 32'h1, 32'h1);
        irq_in[0] = 1'b0;
        wait_n(4);
        bus_addr = 5'h0C; #1; chk("R4 latched after drop", bus_rdata & 32'h1, 32'h1);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd4, 32'h0);
        bus_addr = 5'h0C; #1; chk("R6 zero write no effect", bus_rdata & 32'h1, 32'h1);
        wr(3'd4, 32'h1);
        bus_addr = 5'h0C; #1; chk("R4 R6 cleared", bus_rdata & 32'h1, 32'h0);
        // R4 active low on line 1 with input low
        wr(3'd5, 32'hFFFF_FFFD);
        wait_n(1);
        bus_addr = 5'h0C; #1; chk("R4 active low", bus_rdata & 32'h2, 32'h2);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd4, 32'h2);

        // R5 rising edge line 2, falling edge line 3
        wr(3'd6, 32'h0000_000C);
        wr(3'd5, 32'hFFFF_FFF7);
        irq_in[3] = 1'b1;
        wait_n(4);
        wr(3'd4, 32'h0000_000C);
        irq_in[2] = 1'b1;
        @(negedge clk);
        irq_in[2] = 1'b0;
        irq_in[3] = 1'b0;
        wait_n(4);
        bus_addr = 5'h0C; #1; chk("R5 edges sticky", bus_rdata & 32'hC, 32'hC);
        chk("R8 masked lines low", irq_out & 32'hC, 32'h0);
        wr(3'd0, 32'hFFFF_FFF2);
        chk("R8 unmask reveals", irq_out & 32'hC, 32'hC);
        wr(3'd4, 32'h0000_000C);
        bus_addr = 5'h0C; #1; chk("R5 cleared", bus_rdata & 32'hC, 32'h0);
        // R7 edge and clear in the same cycle on line 2
        irq_in[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(3'd4, 32'h4);
        bus_addr = 5'h0C; #1; chk("R7 set wins", bus_rdata & 32'h4, 32'h4);
        rd_chk("R9 stat", 3'd2);

        // constrained random phase against the model
        for (int c = 0; c < 5000; c++) begin
            logic [2:0] ridx;
            ridx = 3'($urandom_range(0, 7));
            rd_chk("R1 R4 R5 R9 random read", ridx);
            chk("R8 R9 random irq_out", irq_out, m_raw & ~m_mask);
            irq_in = irq_in ^ ($urandom() & $urandom() & $urandom());
            if ($urandom_range(0, 7) == 0) begin
                bus_wr = 1'b1;
                bus_addr = {3'($urandom_range(0, 7)), 2'b00};
                bus_wdata = $urandom();
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule